// File: doc/BRIEF.md
# RSS Receive Queue Resolver

This block turns the result of a packet classifier into the receive queue that will take the packet. Each classifier result carries a five-bit queue-high field, a three-bit queue-low field and a flag that enables receive-side scaling (RSS). It arrives together with the ingress port number and a packet hash. The two fields join into an eight-bit queue number. For each port, configuration can replace the classifier's queue-high with a fixed value, so that port stays inside its own block of queues while the classifier still picks queue-low.

When RSS is off, the resolved queue number is the output. When RSS is on, the resolved queue selects an entry in a queue-to-table map, which names one of the RSS tables. The low hash bits then pick an entry in that table, and the entry holds the final queue. If the lookup hits a map location that was never written, the packet is flagged for drop. Software writes the configuration through an indirect interface: an index register with queue, table and entry fields, then data registers for the map, the tables, the port override mask and the per-port queue-high values.

The path has two register stages and takes one packet per clock. Valid/ready handshakes on the input and the output let the consumer stall it.

Top module: `rxq_resolver`

## Requirements
- R1: After reset, out_valid and out_drop are low and in_ready is high.
- R2: The classifier's queue-high is taken from in_cls_attr bits 28:24 and queue-low from bits 23:21. The resolved queue is queue-high*8 + queue-low. All other bits of that word are ignored.
- R3: When bit p of the override mask (register address 3, bits 3:0) is set for the ingress port p, queue-high comes from that port's register (address 4+p, bits 4:0) and the classifier's queue-high has no effect. Queue-low always comes from the classifier.
- R4: When RSS is disabled, out_queue equals the resolved queue, out_drop is low and the hash has no effect.
- R5: When RSS is enabled, the resolved queue selects a map location, the map gives a table number, and out_queue is the entry of that table selected by in_hash bits 4:0.
- R6: When RSS is enabled and the selected map location has never been written since reset, out_drop is high and out_queue is 0.
- R7: The index register (address 0) holds a queue field at bits 23:16, a table field at bits 10:8 and an entry field at bits 4:0. A write to address 1 stores bits 2:0 as the table number for the indexed queue. A write to address 2 stores bits 7:0 into the indexed table at the indexed entry.
- R8: Reset marks every map location unwritten, and a write to address 1 marks the indexed location written.
- R9: A packet accepted at a clock edge appears on the output two edges later when out_ready is high. Back-to-back packets are accepted one per cycle.
- R10: While out_valid is high and out_ready is low, out_queue and out_drop stay unchanged. No packet is lost, and packets leave in arrival order.
- R11: RSS is enabled by bit 30 of in_cls_rss. All other bits of that word are ignored.
- R12: With the per-port allocation (queue-high forced to port*4, table p holding queues p*32 onward), each port's traffic resolves into that port's own 32-queue range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Classifier result valid |
| in_ready | output | 1 | Resolver can accept a result |
| in_port | input | 2 | Ingress port number |
| in_cls_attr | input | 32 | Classifier attribute word holding the queue fields |
| in_cls_rss | input | 32 | Classifier attribute word holding the RSS enable |
| in_hash | input | 32 | Packet hash |
| out_valid | output | 1 | Resolved result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_queue | output | 8 | Final receive queue |
| out_drop | output | 1 | Lookup hit an unwritten map location |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
A result is due two clock edges after the edge that accepts its input. The bench records the cycle of each acceptance. When out_ready is held high, it requires that the matching output handshake comes exactly two cycles later. When the consumer stalls, the bench no longer fixes the cycle. Instead, a scoreboard queue holds the expected values in arrival order, and each stalled cycle is checked for an unchanged output. Configuration writes only take place after the scoreboard has drained, so each expected value is computed against the configuration that the lookup will use.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    // Field positions inside the classifier words
    localparam int QL_LSB     = 21;
    localparam int QH_LSB     = 24;
    localparam int RSS_EN_BIT = 30;
    // Field positions inside the index register
    localparam int IDX_Q_LSB  = 16;
    localparam int IDX_T_LSB  = 8;
    localparam int IDX_E_LSB  = 0;
    // Configuration register addresses
    localparam int CFG_A_INDEX = 0;
    localparam int CFG_A_MAP   = 1;
    localparam int CFG_A_TBL   = 2;
    localparam int CFG_A_PMASK = 3;
    localparam int CFG_A_HQ0   = 4;
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg #(
    parameter int PORTS  = 4,
    parameter int QH_W   = 5,
    parameter int Q_W    = 8,
    parameter int TBL_W  = 3,
    parameter int ENT_W  = 5,
    parameter int CFG_AW = 3,
    parameter int PORT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [31:0]            cfg_wdata,
    input  logic [PORT_W-1:0]      rd_port,
    output logic                   ovr_en,
    output logic [QH_W-1:0]        ovr_hq,
    input  logic [Q_W-1:0]         map_rd_q,
    output logic                   map_vld,
    output logic [TBL_W-1:0]       map_ptr,
    input  logic [TBL_W+ENT_W-1:0] tbl_rd_addr,
    output logic [Q_W-1:0]         tbl_data
);
    import rxq_pkg::*;

    localparam int NQ    = 1 << Q_W;
    localparam int TSIZE = 1 << (TBL_W + ENT_W);

    typedef struct packed {
        logic [Q_W-1:0]              iq;
        logic [TBL_W-1:0]            it;
        logic [ENT_W-1:0]            ie;
        logic [PORTS-1:0]            pmask;
        logic [PORTS-1:0][QH_W-1:0]  hq;
        logic [NQ-1:0]               mvld;
    } cfg_t;

    cfg_t st_d, st_q;
    logic map_we, tbl_we;

    logic [TBL_W-1:0] map_ptr_q [NQ];
    logic [Q_W-1:0]   tbl_q     [TSIZE];

    assign map_we = cfg_we && (cfg_addr == CFG_AW'(CFG_A_MAP));
    assign tbl_we = cfg_we && (cfg_addr == CFG_AW'(CFG_A_TBL));

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_addr == CFG_AW'(CFG_A_INDEX)) begin
                st_d.iq = cfg_wdata[IDX_Q_LSB +: Q_W];
                st_d.it = cfg_wdata[IDX_T_LSB +: TBL_W];
                st_d.ie = cfg_wdata[IDX_E_LSB +: ENT_W];
            end
            if (cfg_addr == CFG_AW'(CFG_A_PMASK))
                st_d.pmask = cfg_wdata[PORTS-1:0];
            for (int p = 0; p < PORTS; p++) begin
                if (cfg_addr == CFG_AW'(CFG_A_HQ0 + p))
                    st_d.hq[p] = cfg_wdata[QH_W-1:0];
            end
        end
        if (map_we)
            st_d.mvld[st_q.iq] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (map_we) map_ptr_q[st_q.iq] <= cfg_wdata[TBL_W-1:0];
        if (tbl_we) tbl_q[{st_q.it, st_q.ie}] <= cfg_wdata[Q_W-1:0];
    end

    assign ovr_en   = st_q.pmask[rd_port];
    assign ovr_hq   = st_q.hq[rd_port];
    assign map_vld  = st_q.mvld[map_rd_q];
    assign map_ptr  = map_ptr_q[map_rd_q];
    assign tbl_data = tbl_q[tbl_rd_addr];

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    // R8
    map_write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> st_q.mvld[$past(st_q.iq)]);

    // R7
    index_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(CFG_A_INDEX)) |=>
            st_q.iq == $past(cfg_wdata[IDX_Q_LSB +: Q_W]));
endmodule

// File: rtl/rxq_qsel.sv
module rxq_qsel #(
    parameter int QH_W = 5,
    parameter int QL_W = 3
) (
    input  logic                 ovr_en,
    input  logic [QH_W-1:0]      ovr_hq,
    input  logic [QH_W-1:0]      cls_qh,
    input  logic [QL_W-1:0]      cls_ql,
    output logic [QH_W+QL_W-1:0] res_q
);
    logic [QH_W-1:0] qh_sel;

    always_comb begin
        qh_sel = ovr_en ? ovr_hq : cls_qh;
        res_q  = {qh_sel, cls_ql};
    end
endmodule

// File: rtl/rxq_lookup.sv
module rxq_lookup #(
    parameter int Q_W   = 8,
    parameter int TBL_W = 3,
    parameter int ENT_W = 5
) (
    input  logic                   rss_en,
    input  logic [Q_W-1:0]         res_q,
    input  logic [ENT_W-1:0]       hidx,
    input  logic                   map_vld,
    input  logic [TBL_W-1:0]       map_ptr,
    output logic [TBL_W+ENT_W-1:0] tbl_addr,
    input  logic [Q_W-1:0]         tbl_data,
    output logic [Q_W-1:0]         fin_q,
    output logic                   drop
);
    assign tbl_addr = {map_ptr, hidx};

    always_comb begin
        fin_q = res_q;
        drop  = 1'b0;
        if (rss_en) begin
            if (map_vld) begin
                fin_q = tbl_data;
            end else begin
                fin_q = '0;
                drop  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxq_resolver.sv
module rxq_resolver #(
    parameter int PORTS     = 4,
    parameter int QH_W      = 5,
    parameter int QL_W      = 3,
    parameter int N_TABLES  = 8,
    parameter int TBL_DEPTH = 32,
    parameter int HASH_W    = 32,
    parameter int PORT_W    = $clog2(PORTS),
    parameter int CFG_AW    = $clog2(rxq_pkg::CFG_A_HQ0 + PORTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PORT_W-1:0]        in_port,
    input  logic [31:0]              in_cls_attr,
    input  logic [31:0]              in_cls_rss,
    input  logic [HASH_W-1:0]        in_hash,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [QH_W+QL_W-1:0]     out_queue,
    output logic                     out_drop,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [31:0]              cfg_wdata
);
    import rxq_pkg::*;

    localparam int Q_W   = QH_W + QL_W;
    localparam int TBL_W = $clog2(N_TABLES);
    localparam int ENT_W = $clog2(TBL_DEPTH);

    typedef struct packed {
        logic             s1_v;
        logic [Q_W-1:0]   s1_q;
        logic             s1_rss;
        logic [ENT_W-1:0] s1_h;
        logic             s2_v;
        logic [Q_W-1:0]   s2_q;
        logic             s2_drop;
    } pipe_t;

    pipe_t st_d, st_q;
    logic  adv;

    logic                   ovr_en;
    logic [QH_W-1:0]        ovr_hq;
    logic [Q_W-1:0]         res_q;
    logic                   map_vld;
    logic [TBL_W-1:0]       map_ptr;
    logic [TBL_W+ENT_W-1:0] tbl_addr;
    logic [Q_W-1:0]         tbl_data;
    logic [Q_W-1:0]         fin_q;
    logic                   fin_drop;

    rxq_cfg #(
        .PORTS(PORTS), .QH_W(QH_W), .Q_W(Q_W), .TBL_W(TBL_W),
        .ENT_W(ENT_W), .CFG_AW(CFG_AW), .PORT_W(PORT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_port(in_port), .ovr_en(ovr_en), .ovr_hq(ovr_hq),
        .map_rd_q(st_q.s1_q), .map_vld(map_vld), .map_ptr(map_ptr),
        .tbl_rd_addr(tbl_addr), .tbl_data(tbl_data)
    );

    rxq_qsel #(.QH_W(QH_W), .QL_W(QL_W)) u_qsel (
        .ovr_en(ovr_en), .ovr_hq(ovr_hq),
        .cls_qh(in_cls_attr[QH_LSB +: QH_W]),
        .cls_ql(in_cls_attr[QL_LSB +: QL_W]),
        .res_q(res_q)
    );

    rxq_lookup #(.Q_W(Q_W), .TBL_W(TBL_W), .ENT_W(ENT_W)) u_lookup (
        .rss_en(st_q.s1_rss), .res_q(st_q.s1_q), .hidx(st_q.s1_h),
        .map_vld(map_vld), .map_ptr(map_ptr),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .fin_q(fin_q), .drop(fin_drop)
    );

    assign adv = !st_q.s2_v || out_ready;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.s2_v    = st_q.s1_v;
            st_d.s2_q    = fin_q;
            st_d.s2_drop = fin_drop;
            st_d.s1_v    = in_valid;
            st_d.s1_q    = res_q;
            st_d.s1_rss  = in_cls_rss[RSS_EN_BIT];
            st_d.s1_h    = in_hash[ENT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = adv;
    assign out_valid = st_q.s2_v;
    assign out_queue = st_q.s2_q;
    assign out_drop  = st_q.s2_v && st_q.s2_drop;

    logic unused_in_bits;
    assign unused_in_bits = ^{in_hash, in_cls_attr, in_cls_rss};

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_queue) && $stable(out_drop)));

    // R6
    drop_no_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_drop |-> (out_valid && out_queue == '0));

    // R9
    latency_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(st_q.s1_v));

    // R4
    direct_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_v && !st_q.s1_rss && adv) |=>
            (out_queue == $past(st_q.s1_q) && !out_drop));
endmodule

// File: tb/tb_rxq_resolver.sv
`timescale 1ns/1ps
module tb_rxq_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_port = '0;
    logic [31:0] in_cls_attr = '0;
    logic [31:0] in_cls_rss = '0;
    logic [31:0] in_hash = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_queue;
    logic        out_drop;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;

    rxq_resolver dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_port(in_port),
        .in_cls_attr(in_cls_attr), .in_cls_rss(in_cls_rss), .in_hash(in_hash),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_queue(out_queue), .out_drop(out_drop),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit bp_on = 1'b0;
    int bp_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model of the configuration
    bit       m_vld [256];
    int       m_ptr [256];
    int       m_tbl [8][32];
    bit [3:0] m_pmask = '0;
    int       m_hq [4];
    int       m_iq = 0, m_it = 0, m_ie = 0;

    // Scoreboard
    int    sb_q[$];
    bit    sb_d[$];
    int    sb_acc[$];
    bit    sb_lat[$];
    string sb_tag[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = 3'(addr);
        cfg_wdata = data;
        case (addr)
            0: begin m_iq = int'(data[23:16]); m_it = int'(data[10:8]); m_ie = int'(data[4:0]); end
            1: begin m_vld[m_iq] = 1'b1; m_ptr[m_iq] = int'(data[2:0]); end
            2: m_tbl[m_it][m_ie] = int'(data[7:0]);
            3: m_pmask = data[3:0];
            default: m_hq[addr-4] = int'(data[4:0]);
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_index(input int q, input int t, input int e);
        cfg_write(0, (32'(q) << 16) | (32'(t) << 8) | 32'(e));
    endtask

    task automatic send(input int port, input logic [31:0] attr,
                        input logic [31:0] rssw, input logic [31:0] hash,
                        input string tag);
        int qh, ql, rq, eq;
        bit ed;
        qh = m_pmask[port] ? m_hq[port] : int'(attr[28:24]);
        ql = int'(attr[23:21]);
        rq = qh * 8 + ql;
        if (!rssw[30]) begin
            eq = rq; ed = 1'b0;
        end else if (!m_vld[rq]) begin
            eq = 0; ed = 1'b1;
        end else begin
            eq = m_tbl[m_ptr[rq]][hash[4:0]]; ed = 1'b0;
        end
        @(negedge clk);
        in_valid    = 1'b1;
        in_port     = 2'(port);
        in_cls_attr = attr;
        in_cls_rss  = rssw;
        in_hash     = hash;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        sb_q.push_back(eq);
        sb_d.push_back(ed);
        sb_acc.push_back(cyc);
        sb_lat.push_back(!bp_on);
        sb_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_attr(input int qh, input int ql,
                                            input logic [31:0] noise);
        return (noise & 32'hE01F_FFFF) | (32'(qh) << 24) | (32'(ql) << 21);
    endfunction

    // Consumer ready pattern
    initial forever begin
        @(negedge clk);
        out_ready = bp_on ? ((bp_cnt % 3) != 0) : 1'b1;
        bp_cnt++;
    end

    // Monitor
    bit       held_v = 1'b0;
    bit [7:0] held_q;
    bit       held_d;
    initial forever begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (held_v) begin
                // R10 output unchanged during stall
                chk(out_valid && out_queue == held_q && out_drop == held_d,
                    "R10", "stalled output changed", int'(out_queue), int'(held_q));
                held_v = 1'b0;
            end
            if (out_valid && !out_ready) begin
                held_v = 1'b1;
                held_q = out_queue;
                held_d = out_drop;
            end
            if (out_valid && out_ready) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected output", int'(out_queue), -1);
                end else begin
                    int eq, acc;
                    bit ed, lat;
                    string tg;
                    eq = sb_q.pop_front(); ed = sb_d.pop_front();
                    acc = sb_acc.pop_front(); lat = sb_lat.pop_front();
                    tg = sb_tag.pop_front();
                    chk(int'(out_queue) == eq, tg, "queue", int'(out_queue), eq);
                    chk(out_drop == ed, tg, "drop", int'(out_drop), int'(ed));
                    if (lat)
                        chk(cyc == acc + 2, "R9", "latency cycle", cyc - acc, 2);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_hq[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(!out_drop, "R1", "out_drop after reset", int'(out_drop), 0);
        chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

        // R8 reset leaves every map location unwritten -> drop (R6)
        send(0, mk_attr(0, 0, 32'h0), 32'h4000_0000, 32'h5, "R8");
        send(2, mk_attr(9, 6, 32'h0), 32'h4000_0000, 32'h1f, "R6");
        drain();

        // R2, R4, R11: direct path, noise bits, hash ignored
        send(0, mk_attr(0, 1, 32'hFFFF_FFFF), 32'h0, 32'h1234, "R2");
        send(1, mk_attr(31, 7, 32'hA005_5555), 32'h0, 32'hFFFF, "R2");
        send(3, mk_attr(17, 2, 32'h0), 32'hBFFF_FFFF, 32'h7, "R11");
        send(2, mk_attr(4, 0, 32'h0), 32'h0, 32'h0, "R4");
        send(2, mk_attr(4, 0, 32'h0), 32'h0, 32'hFFFF_FFFF, "R4");
        drain();

        // R3 per-port queue-high override
        cfg_write(3, 32'h0000_0006);
        cfg_write(5, 32'd4);
        cfg_write(6, 32'd8);
        send(1, mk_attr(0, 1, 32'h0), 32'h0, 32'h0, "R3");
        send(1, mk_attr(31, 5, 32'h0), 32'h0, 32'h0, "R3");
        send(2, mk_attr(3, 7, 32'h0), 32'h0, 32'h0, "R3");
        send(0, mk_attr(3, 7, 32'h0), 32'h0, 32'h0, "R3");
        drain();

        // R7, R12: per-port allocation, tables and map
        cfg_write(3, 32'h0000_000F);
        for (int p = 0; p < 4; p++) cfg_write(4 + p, 32'(p * 4));
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 32; e++) begin
                set_index(0, p, e);
                cfg_write(2, 32'(p * 32 + (e % 4)));
            end
            for (int ql = 0; ql < 8; ql++) begin
                set_index(p * 32 + ql, 0, 0);
                cfg_write(1, 32'(p));
            end
        end
        set_index(0, 3, 5);
        cfg_write(2, 32'h77);
        set_index(0, 7, 9);
        cfg_write(2, 32'h5A);
        set_index(200, 0, 0);
        cfg_write(1, 32'd7);
        for (int p = 0; p < 4; p++)
            for (int h = 0; h < 6; h++)
                send(p, mk_attr(21, h, 32'h0), 32'h4000_0000, 32'(h * 7 + p), "R12");
        send(3, mk_attr(0, 2, 32'h0), 32'h4000_0000, 32'hFFFF_FFE5, "R5");
        send(3, mk_attr(0, 2, 32'h0), 32'h4000_0000, 32'h0000_0004, "R5");
        drain();

        // R7 table selected through map location 200 (table 7, entry 9)
        cfg_write(3, 32'h0);
        send(0, mk_attr(25, 0, 32'h0), 32'h4000_0000, 32'h29, "R7");
        // R6 unwritten map location
        send(1, mk_attr(20, 3, 32'h0), 32'h4000_0000, 32'h3, "R6");
        drain();

        // R9 back-to-back stream, full throughput
        for (int i = 0; i < 20; i++)
            send(i % 4, mk_attr((i * 5) % 32, i % 8, 32'(i * 31)),
                 (i % 2 == 1) ? 32'h4000_0000 : 32'h0, 32'(i * 13), "R9");
        drain();

        // R10 consumer back-pressure
        bp_on = 1'b1;
        for (int i = 0; i < 30; i++)
            send(i % 4, mk_attr((i * 3) % 32, (i + 1) % 8, 32'h0),
                 (i % 3 == 0) ? 32'h0 : 32'h4000_0000, 32'(i * 11), "R10");
        drain();
        bp_on = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule